// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates an effective address by comparing it, in a single cycle, with every entry of a small bank of block-translation registers. Each register describes one naturally aligned region whose size is a power of two between 128 KB and 256 MB. For that region the register holds an effective base, a physical base, a size code, a valid flag and read, write and execute permissions. Instruction fetches are matched against one bank and data accesses against a second bank. Each bank holds `NUM_ENT` registers, and `NUM_ENT` is 4 or 8.

A hashed page-table search starts in the same cycle as the block lookup. When the lookup finds a region, the block raises `walk_abort` in the cycle of its registered response, and the page-table search is dropped. Software loads the registers through a simple write port. A write takes effect for requests issued after the write cycle.

Top module: `blk_xlate_top`

## Requirements
- R1: After reset, every entry of both banks is invalid, and `rsp_vld`, `rsp_hit`, `rsp_fault` and `walk_abort` are 0.
- R2: A request with `req_is_instr`=1 searches only the instruction bank. A request with `req_is_instr`=0 searches only the data bank. A write goes to the instruction bank when `wr_to_instr`=1 and to the data bank otherwise.
- R3: The region size is 2^(17+code) bytes, so code 0 is 128 KB and code 11 is 256 MB. A code above 11 is treated as 11. An entry matches when it is valid and the effective address agrees with the effective base in every bit at or above the region size.
- R4: On a hit, `rsp_pa` takes the physical base in the bits at or above the region size and the effective address in the bits below it. On a miss, `rsp_pa` is 0.
- R5: When several valid entries of the searched bank match, the entry with the lowest index wins, and `rsp_idx` reports that index.
- R6: The permission field has bit 0 = read, bit 1 = write and bit 2 = execute. An instruction request needs execute. A data request with `req_is_wr`=1 needs write, and any other data request needs read. `rsp_fault` is 1 exactly when the request hits and the winning entry lacks the needed bit.
- R7: The response is registered. `rsp_vld` is 1 in the cycle after a cycle with `req_vld`=1 and 0 otherwise. With no request, `rsp_hit`, `rsp_fault` and `walk_abort` are 0.
- R8: `walk_abort` is 1 in the same cycle as any hit response, including a hit that faults. It is 0 on a miss.
- R9: An entry written with `wr_valid`=0 never matches. A lookup issued in the same cycle as a write sees the bank contents from before the write. The new contents are used from the next request on.
- R10: Bits of the stored effective and physical base that lie below the region size have no effect on matching or on `rsp_pa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one register this cycle |
| wr_to_instr | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | IDX_W | Register index to write |
| wr_valid | input | 1 | Valid flag for the written register |
| wr_eff_base | input | 32 | Effective base of the region |
| wr_phys_base | input | 32 | Physical base of the region |
| wr_code | input | 4 | Size code, region = 2^(17+code) bytes |
| wr_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| req_vld | input | 1 | Lookup request |
| req_is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_is_wr | input | 1 | Data store when 1 (ignored for fetches) |
| req_ea | input | 32 | Effective address to translate |
| rsp_vld | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | A register matched |
| rsp_fault | output | 1 | Hit without the needed permission |
| rsp_idx | output | IDX_W | Index of the winning register |
| rsp_pa | output | 32 | Translated physical address |
| walk_abort | output | 1 | Cancel the parallel page-table search |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any check matters. They also assume that `wr_idx` always addresses an existing register, which is always true when `NUM_ENT` is a power of two. The stimulus holds reset for several edges and only uses indices below `NUM_ENT`.

All inputs change on the falling edge, so each request and each write is seen by exactly one rising edge. The same-cycle case in R9 is exercised on purpose: a write and a request are presented on the same falling edge. Overlapping entries of different sizes are placed in the same bank so that the priority rule in R5 is actually exercised.

// File: rtl/blk_xlate_pkg.sv
// Package: shared constants, the register-entry type and the size-mask helper.
// Assumes a 32-bit effective and physical address space.
package blk_xlate_pkg;

    localparam int XL_EA_W      = 32;   // address width
    localparam int XL_MIN_SHIFT = 17;   // smallest region: 128 KB
    localparam int XL_CODE_MAX  = 11;   // largest region: 256 MB
    localparam int XL_CODE_W    = 4;    // width of the size code
    localparam int XL_PERM_W    = 3;    // read / write / execute

    localparam int XL_PERM_RD = 0;
    localparam int XL_PERM_WR = 1;
    localparam int XL_PERM_EX = 2;

    typedef struct packed {
        logic                 vld;
        logic [XL_EA_W-1:0]   ebase;
        logic [XL_EA_W-1:0]   pbase;
        logic [XL_CODE_W-1:0] code;
        logic [XL_PERM_W-1:0] perm;
    } xl_ent_t;

    // Offset mask for a size code: ones below the region size.
    // Codes above XL_CODE_MAX are clamped to XL_CODE_MAX.
    function automatic logic [XL_EA_W-1:0] xl_code_mask(input logic [XL_CODE_W-1:0] code);
        logic [XL_EA_W-1:0] m;
        int                 lim;
        lim = (int'(code) > XL_CODE_MAX) ? (XL_MIN_SHIFT + XL_CODE_MAX)
                                         : (XL_MIN_SHIFT + int'(code));
        for (int i = 0; i < XL_EA_W; i++) begin
            m[i] = (i < lim);
        end
        return m;
    endfunction

endpackage

// File: rtl/blk_xlate_bank.sv
// Module: blk_xlate_bank
// Holds NUM_ENT translation registers for one access type.
// A write updates one register at the clock edge. Reads are combinational,
// so a lookup in the write cycle sees the old contents.
// Assumes wr_idx < NUM_ENT.
module blk_xlate_bank
    import blk_xlate_pkg::*;
#(
    parameter  int NUM_ENT = 4,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  xl_ent_t          wr_ent,
    output xl_ent_t          ents [NUM_ENT]
);

    xl_ent_t ents_q [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        // Purpose: reset clears the register; a selected write loads it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ents_q[g] <= wr_ent;
            end
        end

        assign ents[g] = ents_q[g];

        // R9
        ent_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (ents[g] == $past(wr_ent)));

        // R9
        ent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(ents[g]));
    end

endmodule

// File: rtl/blk_xlate_cmp.sv
// Module: blk_xlate_cmp
// Compares one effective address with one register and forms the
// physical address that register would produce.
// Assumes nothing about alignment of the stored bases.
module blk_xlate_cmp
    import blk_xlate_pkg::*;
(
    input  xl_ent_t              ent,
    input  logic [XL_EA_W-1:0]   ea,
    output logic                 hit,
    output logic [XL_EA_W-1:0]   pa
);

    logic [XL_EA_W-1:0] offs_mask;

    // Purpose: match the region's upper bits and splice the offset into the physical base.
    always_comb begin
        offs_mask = xl_code_mask(ent.code);
        hit       = ent.vld && ((ea & ~offs_mask) == (ent.ebase & ~offs_mask));
        pa        = (ent.pbase & ~offs_mask) | (ea & offs_mask);
    end

endmodule

// File: rtl/blk_xlate_prio.sv
// Module: blk_xlate_prio
// Picks the lowest-numbered entry among the matching ones.
// Produces a one-hot grant, an any-hit flag and a binary index.
module blk_xlate_prio #(
    parameter  int NUM_ENT = 4,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] match,
    output logic [NUM_ENT-1:0] grant,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Purpose: isolate the lowest set bit and encode its position.
    always_comb begin
        grant = match & (~match + NUM_ENT'(1));
        any   = |match;
        idx   = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~match) == '0) && ((match & (grant - NUM_ENT'(1))) == '0));

endmodule

// File: rtl/blk_xlate_top.sv
// Module: blk_xlate_top
// Block-translation matcher with separate instruction and data banks.
// The lookup is combinational across all entries of the selected bank.
// The response and the page-table abort are registered one cycle after
// the request. NUM_ENT is expected to be 4 or 8.
module blk_xlate_top
    import blk_xlate_pkg::*;
#(
    parameter  int NUM_ENT = 4,
    localparam int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_to_instr,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [XL_EA_W-1:0]   wr_eff_base,
    input  logic [XL_EA_W-1:0]   wr_phys_base,
    input  logic [XL_CODE_W-1:0] wr_code,
    input  logic [XL_PERM_W-1:0] wr_perm,
    input  logic                 req_vld,
    input  logic                 req_is_instr,
    input  logic                 req_is_wr,
    input  logic [XL_EA_W-1:0]   req_ea,
    output logic                 rsp_vld,
    output logic                 rsp_hit,
    output logic                 rsp_fault,
    output logic [IDX_W-1:0]     rsp_idx,
    output logic [XL_EA_W-1:0]   rsp_pa,
    output logic                 walk_abort
);

    xl_ent_t              wr_ent;
    xl_ent_t              ibank [NUM_ENT];
    xl_ent_t              dbank [NUM_ENT];
    xl_ent_t              sel   [NUM_ENT];
    logic [NUM_ENT-1:0]   match;
    logic [NUM_ENT-1:0]   grant;
    logic [XL_EA_W-1:0]   cand_pa [NUM_ENT];
    logic                 any_hit;
    logic [IDX_W-1:0]     win_idx;
    logic [XL_EA_W-1:0]   win_pa;
    logic [XL_PERM_W-1:0] win_perm;
    logic [XL_PERM_W-1:0] need;
    logic                 perm_bad;

    // Purpose: pack the write-port fields into one register image.
    always_comb begin
        wr_ent.vld   = wr_valid;
        wr_ent.ebase = wr_eff_base;
        wr_ent.pbase = wr_phys_base;
        wr_ent.code  = wr_code;
        wr_ent.perm  = wr_perm;
    end

    blk_xlate_bank #(.NUM_ENT(NUM_ENT)) u_ibank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && wr_to_instr),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .ents   (ibank)
    );

    blk_xlate_bank #(.NUM_ENT(NUM_ENT)) u_dbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && !wr_to_instr),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .ents   (dbank)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign sel[g] = req_is_instr ? ibank[g] : dbank[g];

        blk_xlate_cmp u_cmp (
            .ent (sel[g]),
            .ea  (req_ea),
            .hit (match[g]),
            .pa  (cand_pa[g])
        );
    end

    blk_xlate_prio #(.NUM_ENT(NUM_ENT)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .grant (grant),
        .any   (any_hit),
        .idx   (win_idx)
    );

    // Purpose: select the winner's physical address and permissions with an AND-OR mux.
    always_comb begin
        win_pa   = '0;
        win_perm = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            win_pa   = win_pa   | (grant[i] ? cand_pa[i]  : '0);
            win_perm = win_perm | (grant[i] ? sel[i].perm : '0);
        end
    end

    // Purpose: work out which permission the access needs and whether it is missing.
    always_comb begin
        need = '0;
        if (req_is_instr) begin
            need[XL_PERM_EX] = 1'b1;
        end else if (req_is_wr) begin
            need[XL_PERM_WR] = 1'b1;
        end else begin
            need[XL_PERM_RD] = 1'b1;
        end
        perm_bad = any_hit && ((win_perm & need) == '0);
    end

    // Purpose: register the response and the abort one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld    <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_idx    <= '0;
            rsp_pa     <= '0;
            walk_abort <= 1'b0;
        end else begin
            rsp_vld    <= req_vld;
            rsp_hit    <= req_vld && any_hit;
            rsp_fault  <= req_vld && perm_bad;
            rsp_idx    <= (req_vld && any_hit) ? win_idx : '0;
            rsp_pa     <= (req_vld && any_hit) ? win_pa  : '0;
            walk_abort <= req_vld && any_hit;
        end
    end

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    // R7
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !rsp_hit && !walk_abort));

    // R6
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    // R8
    abort_with_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_abort == (rsp_vld && rsp_hit)));

    // R4
    miss_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pa == '0));

endmodule

// File: tb/sim_blk_xlate_top.sv
// Directed bench for blk_xlate_top. Inputs change on the falling edge and
// outputs are sampled on the following falling edge.
module sim_blk_xlate_top;
    import blk_xlate_pkg::*;

    localparam int NUM_ENT = 4;
    localparam int IDX_W   = $clog2(NUM_ENT);

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 wr_en, wr_to_instr, wr_valid;
    logic [IDX_W-1:0]     wr_idx;
    logic [31:0]          wr_eff_base, wr_phys_base;
    logic [3:0]           wr_code;
    logic [2:0]           wr_perm;
    logic                 req_vld, req_is_instr, req_is_wr;
    logic [31:0]          req_ea;
    logic                 rsp_vld, rsp_hit, rsp_fault, walk_abort;
    logic [IDX_W-1:0]     rsp_idx;
    logic [31:0]          rsp_pa;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    blk_xlate_top #(.NUM_ENT(NUM_ENT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_to_instr(wr_to_instr),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_eff_base(wr_eff_base),
        .wr_phys_base(wr_phys_base), .wr_code(wr_code), .wr_perm(wr_perm),
        .req_vld(req_vld), .req_is_instr(req_is_instr), .req_is_wr(req_is_wr),
        .req_ea(req_ea), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_idx(rsp_idx), .rsp_pa(rsp_pa),
        .walk_abort(walk_abort)
    );

    task automatic expect_rsp(input string tag, input logic vld, input logic hit,
                              input logic flt, input int idx, input logic [31:0] pa,
                              input logic abrt);
        checks++;
        if (rsp_vld !== vld || rsp_hit !== hit || rsp_fault !== flt ||
            rsp_pa !== pa || walk_abort !== abrt ||
            (hit && rsp_idx !== IDX_W'(idx))) begin
            errors++;
            $display("FAIL %s: got vld=%0b hit=%0b flt=%0b idx=%0d pa=%h abort=%0b, exp vld=%0b hit=%0b flt=%0b idx=%0d pa=%h abort=%0b",
                     tag, rsp_vld, rsp_hit, rsp_fault, rsp_idx, rsp_pa, walk_abort,
                     vld, hit, flt, idx, pa, abrt);
        end
    endtask

    task automatic put_ent(input logic instr, input int idx, input logic vld,
                           input logic [31:0] eb, input logic [31:0] pb,
                           input logic [3:0] code, input logic [2:0] perm);
        @(negedge clk);
        wr_en = 1'b1; wr_to_instr = instr; wr_idx = IDX_W'(idx); wr_valid = vld;
        wr_eff_base = eb; wr_phys_base = pb; wr_code = code; wr_perm = perm;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic instr, input logic wr, input logic [31:0] ea);
        @(negedge clk);
        req_vld = 1'b1; req_is_instr = instr; req_is_wr = wr; req_ea = ea;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic t_reset;
        expect_rsp("R1 reset outputs", 0, 0, 0, 0, 32'h0, 0);
        look(0, 0, 32'h1000_0000);
        expect_rsp("R1 empty data bank misses", 1, 0, 0, 0, 32'h0, 0);
        look(1, 0, 32'h0000_0000);
        expect_rsp("R1 empty instr bank misses", 1, 0, 0, 0, 32'h0, 0);
    endtask

    task automatic t_basic;
        put_ent(0, 0, 1, 32'h1000_0000, 32'h8000_0000, 4'd0, 3'b011);
        look(0, 0, 32'h1001_2345);
        expect_rsp("R3 R4 R8 128KB hit", 1, 1, 0, 0, 32'h8001_2345, 1);
        look(0, 0, 32'h1002_0000);
        expect_rsp("R3 just above region", 1, 0, 0, 0, 32'h0, 0);
        look(0, 0, 32'h0FFF_FFFF);
        expect_rsp("R3 just below region", 1, 0, 0, 0, 32'h0, 0);
    endtask

    task automatic t_bank;
        look(1, 0, 32'h1001_2345);
        expect_rsp("R2 instr bank ignores data entry", 1, 0, 0, 0, 32'h0, 0);
        put_ent(1, 1, 1, 32'h1000_0000, 32'h2000_0000, 4'd0, 3'b100);
        look(1, 0, 32'h1001_2345);
        expect_rsp("R2 instr bank hit", 1, 1, 0, 1, 32'h2001_2345, 1);
        look(0, 0, 32'h1001_2345);
        expect_rsp("R2 data bank unchanged", 1, 1, 0, 0, 32'h8001_2345, 1);
    endtask

    task automatic t_sizes;
        put_ent(0, 1, 1, 32'h3000_0000, 32'hC000_0000, 4'd11, 3'b111);
        look(0, 0, 32'h3ABC_DEF0);
        expect_rsp("R3 256MB hit", 1, 1, 0, 1, 32'hCABC_DEF0, 1);
        put_ent(0, 1, 1, 32'h3000_0000, 32'hC000_0000, 4'd15, 3'b111);
        look(0, 0, 32'h3ABC_DEF0);
        expect_rsp("R3 code clamps to 256MB", 1, 1, 0, 1, 32'hCABC_DEF0, 1);
        look(0, 0, 32'h4000_0000);
        expect_rsp("R3 clamp not wider", 1, 0, 0, 0, 32'h0, 0);
        put_ent(0, 1, 1, 32'h3000_0000, 32'hC000_0000, 4'd3, 3'b111);
        look(0, 0, 32'h300F_FFFF);
        expect_rsp("R3 1MB top byte", 1, 1, 0, 1, 32'hC00F_FFFF, 1);
        look(0, 0, 32'h3010_0000);
        expect_rsp("R3 1MB outside", 1, 0, 0, 0, 32'h0, 0);
    endtask

    task automatic t_prio;
        put_ent(0, 2, 1, 32'h5000_0000, 32'h7000_0000, 4'd11, 3'b001);
        put_ent(0, 3, 1, 32'h5000_0000, 32'h6000_0000, 4'd3, 3'b001);
        look(0, 0, 32'h5000_1234);
        expect_rsp("R5 lower index wins", 1, 1, 0, 2, 32'h7000_1234, 1);
        look(0, 0, 32'h5800_0000);
        expect_rsp("R5 only large entry", 1, 1, 0, 2, 32'h7800_0000, 1);
        put_ent(0, 2, 0, 32'h5000_0000, 32'h7000_0000, 4'd11, 3'b001);
        look(0, 0, 32'h5000_1234);
        expect_rsp("R9 invalid entry skipped", 1, 1, 0, 3, 32'h6000_1234, 1);
    endtask

    task automatic t_perm;
        look(0, 1, 32'h1000_0010);
        expect_rsp("R6 store allowed", 1, 1, 0, 0, 32'h8000_0010, 1);
        look(0, 1, 32'h5000_0004);
        expect_rsp("R6 R8 store to read-only faults", 1, 1, 1, 3, 32'h6000_0004, 1);
        put_ent(1, 2, 1, 32'h9000_0000, 32'h9000_0000, 4'd0, 3'b011);
        look(1, 0, 32'h9000_0100);
        expect_rsp("R6 fetch without execute faults", 1, 1, 1, 2, 32'h9000_0100, 1);
        look(1, 1, 32'h1000_0000);
        expect_rsp("R6 fetch ignores store flag", 1, 1, 0, 1, 32'h2000_0000, 1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_to_instr = 1'b0; wr_idx = IDX_W'(0); wr_valid = 1'b0;
        wr_eff_base = 32'h1000_0000; wr_phys_base = 32'h8000_0000;
        wr_code = 4'd0; wr_perm = 3'b011;
        req_vld = 1'b1; req_is_instr = 1'b0; req_is_wr = 1'b0; req_ea = 32'h1001_2345;
        @(negedge clk);
        wr_en = 1'b0; req_vld = 1'b0;
        expect_rsp("R9 lookup sees old entry", 1, 1, 0, 0, 32'h8001_2345, 1);
        look(0, 0, 32'h1001_2345);
        expect_rsp("R9 next lookup sees write", 1, 0, 0, 0, 32'h0, 0);
    endtask

    task automatic t_lowbits;
        put_ent(0, 0, 1, 32'h1000_0ABC, 32'h8001_F000, 4'd0, 3'b001);
        look(0, 0, 32'h1000_0004);
        expect_rsp("R10 base low bits ignored", 1, 1, 0, 0, 32'h8000_0004, 1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_vld = 1'b0; req_ea = 32'h1000_0004;
        @(negedge clk);
        expect_rsp("R7 no request no response", 0, 0, 0, 0, 32'h0, 0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_to_instr = 1'b0; wr_idx = '0; wr_valid = 1'b0;
        wr_eff_base = '0; wr_phys_base = '0; wr_code = '0; wr_perm = '0;
        req_vld = 1'b0; req_is_instr = 1'b0; req_is_wr = 1'b0; req_ea = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_bank;
        t_sizes;
        t_prio;
        t_perm;
        t_same_cycle;
        t_lowbits;
        t_idle;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule